// File: doc/BRIEF.md
# Indirect-Mapped GPIO and Soft-Reset Controller

This block is a small control-register file that a host reaches through an indirect map. The host first writes an 8-bit index through the index port. It then reads or writes the register that the index selects through the data port. Three things sit behind the map:

- a fixed identification value that software can use to check the design version;
- a five-pin general-purpose I/O port with a direction register and a data register;
- a write-triggered software reset that returns every other register to its default.

Each GPIO pin is presented as a tri-state triple: an output value, an output enable and an input level. The input level passes through a two-flop synchroniser. The GPIO port can drive simple external logic, such as a serial programming interface.

The hardware reset input is active low. Asserting it clears the block at once, without waiting for a clock. Its release is synchronised to the clock, so the block leaves reset two edges after the input goes high.

Top module: `gpio_ixmap_ctl`

## Requirements
- R1: The data port at index 0x00 always reads 0x20, and writes through the data port at index 0x00 change nothing.
- R2: With host_sel=0, a write loads the 8-bit index register and a read returns it. With host_sel=1, the index picks the register: 0x00 identification, 0x01 direction, 0x02 GPIO data, 0xFF software reset. Reads of any other index return 0x00.
- R3: The direction register is 8 bits wide, readable and writable. Bits 0 to 4 drive pin_oe[4:0] from the edge that takes the write (1 = output, 0 = input).
- R4: The GPIO data register is 8 bits wide. Bits 0 to 4 drive pin_out[4:0] from the edge that takes the write, whatever the pin direction. Bits 5 to 7 are plain storage and read back unchanged.
- R5: For a pin set as input, its data bit reads as pin_in after two synchroniser flops. A read sampled one edge after the pin changes still returns the old level. A read sampled two edges after the change returns the new level.
- R6: For a pin set as output, its data bit reads as the stored bit, and pin_in has no effect on it.
- R7: A data-port write at index 0xFF starts a software reset. At the following clock edge, the index, direction, data and read-data registers all become 0x00. Host accesses in that following cycle are dropped.
- R8: While rst_n is low, pin_oe, pin_out and host_rdata are 0 without any clock edge. After rst_n rises, the block leaves reset two clock edges later.
- R9: host_rdata is loaded on the edge that samples host_re=1 and holds its value while host_re is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| host_sel | input | 1 | Selects the port: 0 = index register, 1 = data port |
| host_we | input | 1 | Write strobe |
| host_re | input | 1 | Read strobe |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Registered read data |
| pin_in | input | 5 | Pin input levels (asynchronous) |
| pin_out | output | 5 | Pin output values |
| pin_oe | output | 5 | Pin output enables |

## Verification
Read data is due one edge after the strobe is sampled, so the monitor compares it at the falling edge that follows. A write shows on pin_out or pin_oe at the edge that takes it. A change on an input pin is visible only to a read sampled two or more edges later. The software reset clears state one edge after the write to 0xFF, so the bench checks the pins both in that pending cycle and in the cycle after it. The bench drives all stimulus on falling edges and checks results on later falling edges, counting each register stage to decide where a value is due.

// File: rtl/ixgp_pkg.sv
package ixgp_pkg;
  localparam int unsigned DW         = 8;
  localparam int unsigned NPIN       = 5;
  localparam logic [DW-1:0] ID_VALUE = 8'h20;
  localparam logic [DW-1:0] IDX_ID   = 8'h00;
  localparam logic [DW-1:0] IDX_DIR  = 8'h01;
  localparam logic [DW-1:0] IDX_DATA = 8'h02;
  localparam logic [DW-1:0] IDX_SRST = 8'hFF;
endpackage

// File: rtl/ixgp_rst_sync.sv
module ixgp_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/ixgp_pin_sync.sv
module ixgp_pin_sync #(
  parameter int unsigned WIDTH = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] meta_q;
  logic [WIDTH-1:0] stab_q;

  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q[g] <= 1'b0;
        stab_q[g] <= 1'b0;
      end else begin
        meta_q[g] <= async_in[g];
        stab_q[g] <= meta_q[g];
      end
    end
  end

  assign sync_out = stab_q;
endmodule

// File: rtl/ixgp_regfile.sv
module ixgp_regfile
  import ixgp_pkg::*;
#(
  parameter int unsigned W  = DW,
  parameter int unsigned NP = NPIN
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel,
  input  logic          we,
  input  logic          re,
  input  logic [W-1:0]  wdata,
  input  logic [NP-1:0] pin_lvl,
  output logic [W-1:0]  rdata,
  output logic [W-1:0]  dir_reg,
  output logic [W-1:0]  dat_reg,
  output logic [W-1:0]  idx_reg,
  output logic          srst_pend
);
  logic [W-1:0] idx_q, idx_d;
  logic [W-1:0] dir_q, dir_d;
  logic [W-1:0] dat_q, dat_d;
  logic [W-1:0] rd_q,  rd_d;
  logic         pend_q, pend_d;
  logic [W-1:0] dat_view;
  logic [W-1:0] port_mux;

  // Data-register view: input pins show the synchronised level.
  always_comb begin
    for (int b = 0; b < int'(W); b++) begin
      if (b < int'(NP)) dat_view[b] = dir_q[b] ? dat_q[b] : pin_lvl[b];
      else              dat_view[b] = dat_q[b];
    end
  end

  always_comb begin
    unique case (idx_q)
      IDX_ID:   port_mux = ID_VALUE;
      IDX_DIR:  port_mux = dir_q;
      IDX_DATA: port_mux = dat_view;
      default:  port_mux = '0;
    endcase
  end

  // Next state
  always_comb begin
    idx_d  = idx_q;
    dir_d  = dir_q;
    dat_d  = dat_q;
    rd_d   = rd_q;
    pend_d = 1'b0;
    if (pend_q) begin
      idx_d = '0;
      dir_d = '0;
      dat_d = '0;
      rd_d  = '0;
    end else begin
      if (we && !sel) idx_d = wdata;
      if (we && sel) begin
        unique case (idx_q)
          IDX_DIR:  dir_d  = wdata;
          IDX_DATA: dat_d  = wdata;
          IDX_SRST: pend_d = 1'b1;
          default:  ;
        endcase
      end
      if (re) rd_d = sel ? port_mux : idx_q;
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      dir_q  <= '0;
      dat_q  <= '0;
      rd_q   <= '0;
      pend_q <= 1'b0;
    end else begin
      idx_q  <= idx_d;
      dir_q  <= dir_d;
      dat_q  <= dat_d;
      rd_q   <= rd_d;
      pend_q <= pend_d;
    end
  end

  assign rdata     = rd_q;
  assign dir_reg   = dir_q;
  assign dat_reg   = dat_q;
  assign idx_reg   = idx_q;
  assign srst_pend = pend_q;
endmodule

// File: rtl/gpio_ixmap_ctl.sv
module gpio_ixmap_ctl
  import ixgp_pkg::*;
#(
  parameter int unsigned W  = DW,
  parameter int unsigned NP = NPIN
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_sel,
  input  logic          host_we,
  input  logic          host_re,
  input  logic [W-1:0]  host_wdata,
  output logic [W-1:0]  host_rdata,
  input  logic [NP-1:0] pin_in,
  output logic [NP-1:0] pin_out,
  output logic [NP-1:0] pin_oe
);
  logic          rst_core_n;
  logic [NP-1:0] pin_lvl;
  logic [W-1:0]  dir_reg;
  logic [W-1:0]  dat_reg;
  logic [W-1:0]  idx_reg;
  logic          srst_pend;

  ixgp_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  ixgp_pin_sync #(.WIDTH(NP)) u_psync (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .async_in (pin_in),
    .sync_out (pin_lvl)
  );

  ixgp_regfile #(.W(W), .NP(NP)) u_regs (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .sel       (host_sel),
    .we        (host_we),
    .re        (host_re),
    .wdata     (host_wdata),
    .pin_lvl   (pin_lvl),
    .rdata     (host_rdata),
    .dir_reg   (dir_reg),
    .dat_reg   (dat_reg),
    .idx_reg   (idx_reg),
    .srst_pend (srst_pend)
  );

  assign pin_out = dat_reg[NP-1:0];
  assign pin_oe  = dir_reg[NP-1:0];
endmodule

// File: rtl/ixgp_chk.sv
module ixgp_chk
  import ixgp_pkg::*;
#(
  parameter int unsigned W  = DW,
  parameter int unsigned NP = NPIN
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rst_core_n,
  input logic          host_sel,
  input logic          host_we,
  input logic          host_re,
  input logic [NP-1:0] wr_low,
  input logic [W-1:0]  host_rdata,
  input logic [NP-1:0] pin_out,
  input logic [NP-1:0] pin_oe,
  input logic [W-1:0]  idx_reg,
  input logic          srst_pend
);
  a_r1_id_reads_fixed: assert property (@(posedge clk) disable iff (!rst_core_n)
    (host_re && host_sel && idx_reg == IDX_ID && !srst_pend) |=> host_rdata == ID_VALUE);

  a_r3_oe_takes_write: assert property (@(posedge clk) disable iff (!rst_core_n)
    (host_we && host_sel && idx_reg == IDX_DIR && !srst_pend) |=> pin_oe == $past(wr_low));

  a_r4_out_takes_write: assert property (@(posedge clk) disable iff (!rst_core_n)
    (host_we && host_sel && idx_reg == IDX_DATA && !srst_pend) |=> pin_out == $past(wr_low));

  a_r6_output_bits_stored: assert property (@(posedge clk) disable iff (!rst_core_n)
    (host_re && host_sel && idx_reg == IDX_DATA && !srst_pend)
      |=> (host_rdata[NP-1:0] & $past(pin_oe)) == ($past(pin_out) & $past(pin_oe)));

  a_r7_soft_clear: assert property (@(posedge clk) disable iff (!rst_core_n)
    srst_pend |=> (pin_oe == '0 && pin_out == '0 && idx_reg == '0 && host_rdata == '0));

  a_r9_rdata_holds: assert property (@(posedge clk) disable iff (!rst_core_n)
    (!host_re && !srst_pend) |=> $stable(host_rdata));

  always @(posedge clk) begin
    if (!rst_n) begin
      a_r8_reset_quiet: assert (pin_oe == '0 && pin_out == '0 && host_rdata == '0);
    end
  end
endmodule

bind gpio_ixmap_ctl ixgp_chk #(.W(W), .NP(NP)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rst_core_n (rst_core_n),
  .host_sel   (host_sel),
  .host_we    (host_we),
  .host_re    (host_re),
  .wr_low     (host_wdata[NP-1:0]),
  .host_rdata (host_rdata),
  .pin_out    (pin_out),
  .pin_oe     (pin_oe),
  .idx_reg    (idx_reg),
  .srst_pend  (srst_pend)
);

// File: tb/test_gpio_ixmap_ctl.sv
`timescale 1ns/1ps
module test_gpio_ixmap_ctl;
  logic       clk;
  logic       rst_n;
  logic       host_sel, host_we, host_re;
  logic [7:0] host_wdata;
  logic [7:0] host_rdata;
  logic [4:0] pin_in, pin_out, pin_oe;

  int n_cmp = 0;
  int n_bad = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic       fire_q;
  logic       done = 1'b0;

  gpio_ixmap_ctl i_gpio_ixmap_ctl (
    .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_we(host_we),
    .host_re(host_re), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // Monitor: a read issued at one falling edge is sampled at the next rising
  // edge and compared at the falling edge after that.
  always @(posedge clk) fire_q <= host_re;
  always @(negedge clk) begin
    if (fire_q === 1'b1) begin
      if (exp_q.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL R9: unexpected read data %h expected none", host_rdata);
      end else begin
        check(tag_q.pop_front(), host_rdata, exp_q.pop_front());
      end
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic s, input logic [7:0] v);
    host_sel = s; host_we = 1'b1; host_wdata = v;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic rd(input logic s, input logic [7:0] exp, input string tag);
    host_sel = s; host_re = 1'b1;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    host_re = 1'b0;
  endtask

  task automatic pins(input string tag, input logic [4:0] oe, input logic [4:0] out);
    check({tag, " oe"},  {3'b0, pin_oe},  {3'b0, oe});
    check({tag, " out"}, {3'b0, pin_out}, {3'b0, out});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; host_sel = 1'b0; host_we = 1'b0; host_re = 1'b0;
    host_wdata = '0; pin_in = '0;
    idle(3);
    pins("R8 reset state", 5'h00, 5'h00);
    rst_n = 1'b1;
    idle(4);

    rd(1'b0, 8'h00, "R2 index after reset");
    rd(1'b1, 8'h20, "R1 id value");
    wr(1'b1, 8'h5A);
    rd(1'b1, 8'h20, "R1 id write ignored");
    pins("R1 id write no pin effect", 5'h00, 5'h00);

    wr(1'b0, 8'h37);
    rd(1'b0, 8'h37, "R2 index readback");
    rd(1'b1, 8'h00, "R2 unmapped index");

    // Mixed directions: pins 0 and 2 output.
    pin_in = 5'b01010;
    wr(1'b0, 8'h01);
    wr(1'b1, 8'hE5);
    pins("R3 direction write", 5'b00101, 5'h00);
    rd(1'b1, 8'hE5, "R3 direction readback");
    wr(1'b0, 8'h02);
    wr(1'b1, 8'hB3);
    pins("R4 data write", 5'b00101, 5'b10011);
    rd(1'b1, 8'hAB, "R5 R6 mixed data read");

    // All inputs, synchroniser latency.
    wr(1'b0, 8'h01);
    wr(1'b1, 8'h00);
    pin_in = 5'h00;
    idle(3);
    wr(1'b0, 8'h02);
    rd(1'b1, 8'hA0, "R5 inputs low");
    pin_in = 5'h1F;
    idle(1);
    rd(1'b1, 8'hA0, "R5 one edge still old");
    rd(1'b1, 8'hBF, "R5 two edges new level");
    wr(1'b1, 8'h15);
    pins("R4 out while input", 5'h00, 5'h15);

    // Outputs ignore pins.
    wr(1'b0, 8'h01);
    wr(1'b1, 8'h1F);
    wr(1'b0, 8'h02);
    wr(1'b1, 8'h40);
    rd(1'b1, 8'h40, "R6 outputs ignore pin_in");
    idle(2);
    check("R9 rdata holds", host_rdata, 8'h40);

    // Software reset.
    wr(1'b0, 8'h01);
    wr(1'b1, 8'hFF);
    wr(1'b0, 8'h02);
    wr(1'b1, 8'hFF);
    wr(1'b0, 8'hFF);
    wr(1'b1, 8'h3C);
    pins("R7 pending cycle", 5'h1F, 5'h1F);
    idle(1);
    pins("R7 cleared", 5'h00, 5'h00);
    pin_in = 5'h00;
    idle(3);
    rd(1'b0, 8'h00, "R7 index cleared");
    wr(1'b0, 8'h01);
    rd(1'b1, 8'h00, "R7 direction cleared");
    wr(1'b0, 8'h02);
    rd(1'b1, 8'h00, "R7 data cleared");

    // Hardware reset mid-run, no clock edge needed.
    wr(1'b0, 8'h01);
    wr(1'b1, 8'h1F);
    wr(1'b0, 8'h02);
    wr(1'b1, 8'h0A);
    rd(1'b1, 8'h0A, "R6 before hw reset");
    #1 rst_n = 1'b0;
    #0.5;
    pins("R8 async clear", 5'h00, 5'h00);
    check("R8 rdata clear", host_rdata, 8'h00);
    idle(3);
    rst_n = 1'b1;
    idle(4);
    rd(1'b0, 8'h00, "R8 index default");
    rd(1'b1, 8'h20, "R8 R1 id after reset");
    idle(2);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule